// File: doc/BRIEF.md
# Filtering Synchronous HDLC Frame Receiver

This block turns a serial HDLC bit stream into a stream of frame bytes. Each incoming bit arrives with a one-cycle strobe on the system clock. The receiver waits for an opening flag, then removes the zero bits that the sender inserted after runs of five ones. It packs the remaining bits into bytes, least significant bit first.

The first two bytes of a frame form a 16-bit address. That address is masked and compared against four programmable address registers. A frame that hits one of them is passed to the output byte stream, including its address and its two frame check bytes. A frame that hits none of them vanishes without any trace at the outputs.

At the frame's end the block reports a status word and the total byte count, and pulses a frame-received event. The status word flags a bad check sequence, an overlong frame, a short or misaligned frame, and an abort. Configuration is taken from static input ports.

Top module: `hdlc_addr_rx`

## Requirements
- R1: While `rx_en` is low, and after it rises until the first flag (0x7E) has been received, no byte, event or status reaches the outputs, whatever bits arrive.
- R2: A 0 that follows five consecutive 1s is deleted from the data, so payload bytes such as 0xFF and 0x7E are delivered unchanged.
- R3: The address is byte0 in bits 7:0 and byte1 in bits 15:8. A frame is accepted when (address & `cfg_mask`) equals (register & `cfg_mask`) for any of the four registers; register i is `cfg_addr[16*i+15:16*i]`.
- R4: An all-ones address has no special handling. It is accepted only when some register, after masking, equals the masked all-ones value.
- R5: A frame whose address hits no register produces no output byte, no event and no change of `frm_status`/`frm_len`.
- R6: An accepted frame's bytes (address, payload, both check bytes) leave in arrival order on `out_data` with `out_vld`. `out_last` marks only the final byte, and `frm_done` pulses for one cycle together with it.
- R7: `frm_len` reports the number of bytes of the frame including the check bytes, saturating at all ones.
- R8: Status bit1 is set when the byte count exceeds `cfg_max_len`. The whole frame is still delivered and its true length is reported.
- R9: The check is CRC-16 (polynomial 0x1021, bit-reversed processing, initial 0xFFFF), and the sender transmits the complemented CRC low byte first. Status bit0 is set when the register after the last check byte is not 0xF0B8.
- R10: A frame that closes with fewer than 4 bytes, or with a bit count that is not a whole number of bytes, sets status bit2 and leaves bit0 clear.
- R11: Seven consecutive 1s abort an accepted frame. The final byte is emitted with `out_last`, and `frm_done` is given with status bit3. The receiver then hunts for a new flag.
- R12: A single flag between two frames closes the first frame and opens the second, and both are received.
- R13: After reset, `out_vld`, `out_last`, `frm_done`, `frm_status` and `frm_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low forces flag hunt |
| rx_bit_vld | input | 1 | Strobe: `rx_bit` carries a new line bit |
| rx_bit | input | 1 | Serial line bit |
| cfg_addr | input | 16*NUM_ADDR | Address registers, register i in bits 16*i+15:16*i |
| cfg_mask | input | 16 | Mask applied to address and registers |
| cfg_max_len | input | LEN_W | Largest frame byte count without violation |
| out_data | output | 8 | Frame byte |
| out_vld | output | 1 | `out_data` is valid this cycle |
| out_last | output | 1 | Final byte of the frame |
| frm_done | output | 1 | One-cycle frame-received event |
| frm_status | output | 4 | bit0 CRC error, bit1 length violation, bit2 short/non-octet, bit3 abort |
| frm_len | output | LEN_W | Total frame byte count |

## Verification
A wrong run-of-ones count corrupts either the bytes or the flag detection. The effect shows as a wrong byte value, a missing `frm_done`, or a frame merged with its neighbour, all visible at the first closing flag. A wrong bit position inside the byte packer shows up as a non-octet status or a CRC error on the very next frame. A wrong address decision either loses a whole frame or delivers one that should vanish. A stale CRC or length register appears in `frm_status` and `frm_len` at the end of the frame that follows an error frame. All of these appear within three clock cycles after the closing flag's last bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 2 * BYTE_W;
  localparam int BITIDX_W   = $clog2(BYTE_W);
  localparam int CRC_W      = 16;
  localparam int STAT_W     = 4;
  localparam int MIN_BYTES  = 4;
  localparam int STUFF_RUN  = 5;

  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESID = 16'hF0B8;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'h8408;

  // bit index of each status flag
  localparam int ST_CRC   = 0;
  localparam int ST_LONG  = 1;
  localparam int ST_SHORT = 2;
  localparam int ST_ABORT = 3;

  // data bits pushed from a closing flag before it is recognised
  localparam logic [BITIDX_W-1:0] FLAG_TAIL = BITIDX_W'(STUFF_RUN + 1);

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_ADDR = 2'd1,
    RX_PASS = 2'd2,
    RX_DROP = 2'd3
  } rx_state_e;

  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_bit_destuff.sv
module hdlc_bit_destuff
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic push_vld,
  output logic push_bit,
  output logic flag_evt,
  output logic abort_evt
);

  localparam logic [2:0] RUN_STUFF = 3'(STUFF_RUN);
  localparam logic [2:0] RUN_FLAG  = 3'(STUFF_RUN + 1);
  localparam logic [2:0] RUN_IDLE  = 3'(STUFF_RUN + 2);

  logic [2:0] ones_q, ones_d;
  logic       pv_d, pb_d, fl_d, ab_d;

  always_comb begin
    ones_d = ones_q;
    pv_d   = 1'b0;
    pb_d   = push_bit;
    fl_d   = 1'b0;
    ab_d   = 1'b0;
    if (bit_vld) begin
      if (bit_in) begin
        if (ones_q == RUN_STUFF) begin
          ones_d = RUN_FLAG;
        end else if (ones_q == RUN_FLAG) begin
          ones_d = RUN_IDLE;
          ab_d   = 1'b1;
        end else if (ones_q == RUN_IDLE) begin
          ones_d = RUN_IDLE;
        end else begin
          ones_d = ones_q + 3'd1;
          pv_d   = 1'b1;
          pb_d   = 1'b1;
        end
      end else begin
        ones_d = 3'd0;
        if (ones_q == RUN_FLAG) begin
          fl_d = 1'b1;
        end else if (ones_q < RUN_STUFF) begin
          pv_d = 1'b1;
          pb_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= RUN_IDLE;
      push_vld  <= 1'b0;
      push_bit  <= 1'b0;
      flag_evt  <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      ones_q    <= ones_d;
      push_vld  <= pv_d;
      push_bit  <= pb_d;
      flag_evt  <= fl_d;
      abort_evt <= ab_d;
    end
  end

  // R11
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);

  // R2
  push_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> !abort_evt);

endmodule

// File: rtl/hdlc_byte_asm.sv
module hdlc_byte_asm
  import hdlc_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_vld,
  input  logic                push_bit,
  input  logic                flag_evt,
  input  logic                abort_evt,
  output logic                byte_vld,
  output logic [BYTE_W-1:0]   byte_data,
  output logic                close_vld,
  output logic [BITIDX_W-1:0] close_rem,
  output logic                abort_vld
);

  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [BITIDX_W-1:0] cnt_q, cnt_d;
  logic                bv_d, cv_d, av_d;
  logic [BYTE_W-1:0]   bd_d;
  logic [BITIDX_W-1:0] cr_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    bv_d  = 1'b0;
    bd_d  = byte_data;
    cv_d  = 1'b0;
    cr_d  = close_rem;
    av_d  = 1'b0;
    if (flag_evt) begin
      cv_d  = 1'b1;
      cr_d  = cnt_q;
      cnt_d = '0;
    end else if (abort_evt) begin
      av_d  = 1'b1;
      cnt_d = '0;
    end else if (push_vld) begin
      sh_d  = {push_bit, sh_q[BYTE_W-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == BITIDX_W'(BYTE_W - 1)) begin
        bv_d = 1'b1;
        bd_d = sh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      close_vld <= 1'b0;
      close_rem <= '0;
      abort_vld <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      byte_vld  <= bv_d;
      byte_data <= bd_d;
      close_vld <= cv_d;
      close_rem <= cr_d;
      abort_vld <= av_d;
    end
  end

  // R2
  byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R12
  close_byte_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_vld |-> !byte_vld);

endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR = 4
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-1:0]          mask,
  input  logic [NUM_ADDR*ADDR_W-1:0] regs,
  output logic                       hit
);

  logic [NUM_ADDR-1:0] hit_vec;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    assign hit_vec[i] = ((addr & mask) == (regs[i*ADDR_W +: ADDR_W] & mask));
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR = 4,
  parameter int LEN_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_en,
  input  logic                       rx_bit_vld,
  input  logic                       rx_bit,
  input  logic [NUM_ADDR*ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0]          cfg_mask,
  input  logic [LEN_W-1:0]           cfg_max_len,
  output logic [BYTE_W-1:0]          out_data,
  output logic                       out_vld,
  output logic                       out_last,
  output logic                       frm_done,
  output logic [STAT_W-1:0]          frm_status,
  output logic [LEN_W-1:0]           frm_len
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic                push_vld, push_bit, flag_evt, abort_evt;
  logic                byte_vld, close_vld, abort_vld;
  logic [BYTE_W-1:0]   byte_data;
  logic [BITIDX_W-1:0] close_rem;
  logic                addr_hit;

  hdlc_bit_destuff u_destuff (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bit_vld   (rx_bit_vld),
    .bit_in    (rx_bit),
    .push_vld  (push_vld),
    .push_bit  (push_bit),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt)
  );

  hdlc_byte_asm u_asm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push_vld  (push_vld),
    .push_bit  (push_bit),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .close_vld (close_vld),
    .close_rem (close_rem),
    .abort_vld (abort_vld)
  );

  rx_state_e         st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [BYTE_W-1:0] b0_q, b0_d;
  logic [BYTE_W-1:0] pend_q, pend_d;

  logic [BYTE_W-1:0] od_d;
  logic              ov_d, ol_d, dn_d;
  logic [STAT_W-1:0] fs_d;
  logic [LEN_W-1:0]  fl_d;

  logic              len_over, short_or_odd;
  logic [LEN_W-1:0]  cnt_inc;

  hdlc_addr_match #(.NUM_ADDR(NUM_ADDR)) u_match (
    .addr (({byte_data, b0_q})),
    .mask (cfg_mask),
    .regs (cfg_addr),
    .hit  (addr_hit)
  );

  assign len_over     = (cnt_q > cfg_max_len);
  assign short_or_odd = (close_rem != FLAG_TAIL) || (cnt_q < LEN_MIN);
  assign cnt_inc      = (cnt_q == LEN_MAX) ? LEN_MAX : cnt_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    crc_d  = crc_q;
    b0_d   = b0_q;
    pend_d = pend_q;
    ov_d   = 1'b0;
    ol_d   = 1'b0;
    dn_d   = 1'b0;
    od_d   = out_data;
    fs_d   = frm_status;
    fl_d   = frm_len;

    if (!rx_en) begin
      st_d = RX_HUNT;
    end else begin
      unique case (st_q)
        RX_HUNT: begin
          if (close_vld) begin
            st_d  = RX_ADDR;
            cnt_d = '0;
            crc_d = CRC_SEED;
          end
        end
        RX_ADDR: begin
          if (abort_vld) begin
            st_d = RX_HUNT;
          end else if (close_vld) begin
            cnt_d = '0;
            crc_d = CRC_SEED;
          end else if (byte_vld) begin
            cnt_d = cnt_inc;
            crc_d = crc_step_byte(crc_q, byte_data);
            if (cnt_q == '0) begin
              b0_d = byte_data;
            end else if (addr_hit) begin
              ov_d   = 1'b1;
              od_d   = b0_q;
              pend_d = byte_data;
              st_d   = RX_PASS;
            end else begin
              st_d = RX_DROP;
            end
          end
        end
        RX_PASS: begin
          if (abort_vld) begin
            ov_d = 1'b1;
            ol_d = 1'b1;
            dn_d = 1'b1;
            od_d = pend_q;
            fl_d = cnt_q;
            fs_d = '0;
            fs_d[ST_ABORT] = 1'b1;
            fs_d[ST_LONG]  = len_over;
            st_d = RX_HUNT;
          end else if (close_vld) begin
            ov_d = 1'b1;
            ol_d = 1'b1;
            dn_d = 1'b1;
            od_d = pend_q;
            fl_d = cnt_q;
            fs_d = '0;
            fs_d[ST_SHORT] = short_or_odd;
            fs_d[ST_CRC]   = !short_or_odd && (crc_q != CRC_RESID);
            fs_d[ST_LONG]  = len_over;
            st_d  = RX_ADDR;
            cnt_d = '0;
            crc_d = CRC_SEED;
          end else if (byte_vld) begin
            cnt_d  = cnt_inc;
            crc_d  = crc_step_byte(crc_q, byte_data);
            ov_d   = 1'b1;
            od_d   = pend_q;
            pend_d = byte_data;
          end
        end
        RX_DROP: begin
          if (abort_vld) begin
            st_d = RX_HUNT;
          end else if (close_vld) begin
            st_d  = RX_ADDR;
            cnt_d = '0;
            crc_d = CRC_SEED;
          end
        end
        default: st_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q       <= RX_HUNT;
      cnt_q      <= '0;
      crc_q      <= CRC_SEED;
      b0_q       <= '0;
      pend_q     <= '0;
      out_vld    <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      frm_done   <= 1'b0;
      frm_status <= '0;
      frm_len    <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      crc_q      <= crc_d;
      b0_q       <= b0_d;
      pend_q     <= pend_d;
      out_vld    <= ov_d;
      out_last   <= ol_d;
      out_data   <= od_d;
      frm_done   <= dn_d;
      frm_status <= fs_d;
      frm_len    <= fl_d;
    end
  end

  // R6
  last_with_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_last |-> (frm_done && out_vld));

  // R6
  done_with_last_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    frm_done |-> out_last);

  // R5
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == RX_DROP) |=> !out_vld);

  // R3
  done_has_addr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    frm_done |-> (frm_len >= LEN_W'(2)));

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    frm_done |-> !(frm_status[ST_CRC] && frm_status[ST_SHORT]));

  // R1
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == RX_HUNT) |=> !out_vld);

endmodule

// File: tb/hdlc_addr_rx_tb.sv
`timescale 1ns/1ps
module hdlc_addr_rx_tb_top;

  logic        clk;
  logic        rst_n;
  logic        rx_en;
  logic        rx_bit_vld;
  logic        rx_bit;
  logic [63:0] cfg_addr;
  logic [15:0] cfg_mask;
  logic [15:0] cfg_max_len;
  logic [7:0]  out_data;
  logic        out_vld;
  logic        out_last;
  logic        frm_done;
  logic [3:0]  frm_status;
  logic [15:0] frm_len;

  hdlc_addr_rx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rx_bit_vld  (rx_bit_vld),
    .rx_bit      (rx_bit),
    .cfg_addr    (cfg_addr),
    .cfg_mask    (cfg_mask),
    .cfg_max_len (cfg_max_len),
    .out_data    (out_data),
    .out_vld     (out_vld),
    .out_last    (out_last),
    .frm_done    (frm_done),
    .frm_status  (frm_status),
    .frm_len     (frm_len)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks;
  int n_errors;
  bit finished;

  // output capture
  logic [7:0] cap_d [0:511];
  logic       cap_l [0:511];
  int         n_cap;
  int         n_done;

  initial begin
    n_cap  = 0;
    n_done = 0;
  end

  always @(negedge clk) begin
    if (out_vld && n_cap < 512) begin
      cap_d[n_cap] = out_data;
      cap_l[n_cap] = out_last;
      n_cap = n_cap + 1;
    end
    if (frm_done) n_done = n_done + 1;
  end

  // expected frame
  logic [7:0] fb [0:63];
  int         fn;
  int         ones;

  // {addr16, payload count 8, seed 8, accept 4, status 4}
  localparam logic [39:0] VEC [0:6] = '{
    40'h1234_03_10_1_0,
    40'h567A_04_21_1_0,
    40'h1240_03_33_0_0,
    40'hFFFF_02_44_1_0,
    40'hABC5_0A_55_1_2,
    40'hABC0_04_FF_1_0,
    40'h0009_01_66_0_0
  };

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit     = b;
    rx_bit_vld = 1'b1;
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) begin
        ones++;
        if (ones == 5) begin
          send_bit(1'b0);
          ones = 0;
        end
      end else begin
        ones = 0;
      end
    end
  endtask

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic build(input logic [15:0] addr, input int npay, input logic [7:0] seed);
    logic [15:0] c;
    fb[0] = addr[7:0];
    fb[1] = addr[15:8];
    for (int i = 0; i < npay; i++) fb[2+i] = seed ^ 8'(i * 8'h81);
    fn = 2 + npay;
    c = 16'hFFFF;
    for (int i = 0; i < fn; i++) c = crc_add(c, fb[i]);
    c = ~c;
    fb[fn]   = c[7:0];
    fb[fn+1] = c[15:8];
    fn = fn + 2;
  endtask

  task automatic send_frame_body();
    for (int i = 0; i < fn; i++) send_byte(fb[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send the built frame between flags and compare
  task automatic run_frame(input string req, input bit acc, input logic [3:0] st);
    int c0, d0;
    bit same;
    c0 = n_cap;
    d0 = n_done;
    send_flag();
    send_frame_body();
    send_flag();
    idle(8);
    if (acc) begin
      chk(n_done - d0 == 1, {req, " one frame event"}, n_done - d0, 1);
      chk(n_cap - c0 == fn, {req, " byte count"}, n_cap - c0, fn);
      same = 1'b1;
      for (int i = 0; i < fn; i++) begin
        if (cap_d[c0+i] != fb[i]) same = 1'b0;
        if (cap_l[c0+i] != (i == fn - 1)) same = 1'b0;
      end
      chk(same, {req, " byte contents and last marker"}, 0, 1);
      chk(frm_status == st, {req, " status"}, frm_status, st);
      chk(frm_len == 16'(fn), "R7 frame length", frm_len, fn);
    end else begin
      chk(n_done == d0, {req, " no event"}, n_done - d0, 0);
      chk(n_cap == c0, {req, " no bytes"}, n_cap - c0, 0);
    end
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    ones = 0;
    rst_n = 1'b0;
    rx_en = 1'b0;
    rx_bit_vld = 1'b0;
    rx_bit = 1'b1;
    cfg_addr = {16'hFFFF, 16'h5670, 16'hABC0, 16'h1230};
    cfg_mask = 16'hFFF0;
    cfg_max_len = 16'd12;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R13 reset state
    chk(!out_vld && !out_last && !frm_done, "R13 reset outputs", {out_vld, out_last, frm_done}, 0);
    chk(frm_status == 4'h0 && frm_len == 16'h0, "R13 reset status/len", frm_status, 0);

    // R1 disabled receiver
    build(16'h1230, 3, 8'h01);
    run_frame("R1 disabled", 1'b0, 4'h0);
    rx_en = 1'b1;
    idle(2);
    // R1 bytes before the first flag are ignored
    begin
      int c0, d0;
      c0 = n_cap;
      d0 = n_done;
      send_frame_body();
      send_flag();
      send_flag();
      idle(8);
      chk(n_done == d0 && n_cap == c0, "R1 hunt ignores data", n_cap - c0, 0);
    end

    // table of frames
    for (int k = 0; k < 7; k++) begin
      logic [39:0] v;
      string req;
      v = VEC[k];
      build(v[39:24], int'(v[23:16]), v[15:8]);
      if (v[7:4] == 4'h0)            req = "R5";
      else if (v[39:24] == 16'hFFFF) req = "R4";
      else if (v[3:0] == 4'h2)       req = "R8";
      else if (v[15:8] == 8'hFF)     req = "R2";
      else                           req = "R3 R6";
      run_frame(req, v[4], v[3:0]);
    end

    // R4 all-ones address dropped without an all-ones register
    cfg_addr[63:48] = 16'h0000;
    build(16'hFFFF, 2, 8'h77);
    run_frame("R4 no broadcast", 1'b0, 4'h0);
    cfg_addr[63:48] = 16'hFFFF;

    // R9 corrupted check sequence
    build(16'h1230, 3, 8'h88);
    fb[fn-1] = fb[fn-1] ^ 8'h01;
    run_frame("R9 bad CRC", 1'b1, 4'h1);

    // R10 short frame
    begin
      int d0;
      d0 = n_done;
      send_flag();
      send_byte(8'h30); send_byte(8'h12); send_byte(8'h55);
      send_flag();
      idle(8);
      chk(n_done - d0 == 1, "R10 short frame event", n_done - d0, 1);
      chk(frm_status == 4'h4, "R10 short status", frm_status, 4);
      chk(frm_len == 16'd3, "R10 short length", frm_len, 3);
    end

    // R10 non-octet frame
    begin
      int d0;
      d0 = n_done;
      build(16'h1230, 2, 8'h60);
      send_flag();
      send_frame_body();
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      send_flag();
      idle(8);
      chk(n_done - d0 == 1, "R10 non-octet event", n_done - d0, 1);
      chk(frm_status == 4'h4, "R10 non-octet status", frm_status, 4);
    end

    // R11 abort, then recovery
    begin
      int c0, d0;
      c0 = n_cap;
      d0 = n_done;
      send_flag();
      send_byte(8'h30); send_byte(8'h12); send_byte(8'hAA); send_byte(8'h00);
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      idle(8);
      chk(n_done - d0 == 1, "R11 abort event", n_done - d0, 1);
      chk(frm_status == 4'h8, "R11 abort status", frm_status, 8);
      chk(n_cap - c0 == 4 && cap_l[c0+3], "R11 abort bytes", n_cap - c0, 4);
      build(16'h5671, 2, 8'h19);
      run_frame("R11 after abort", 1'b1, 4'h0);
    end

    // R12 back-to-back frames sharing one flag
    begin
      int c0, d0, na;
      c0 = n_cap;
      d0 = n_done;
      build(16'h1231, 3, 8'h2C);
      na = fn;
      send_flag();
      send_frame_body();
      build(16'hABC2, 4, 8'h3D);
      send_flag();
      send_frame_body();
      send_flag();
      idle(8);
      chk(n_done - d0 == 2, "R12 two events", n_done - d0, 2);
      chk(n_cap - c0 == na + fn, "R12 total bytes", n_cap - c0, na + fn);
      chk(cap_l[c0+na-1] && frm_status == 4'h0, "R12 first last and status", frm_status, 0);
      chk(frm_len == 16'(fn), "R12 second length", frm_len, fn);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule